// File: doc/BRIEF.md
# Basic Up-Counting Timer with Update-Event Control

This block is a programmable up-counter for general timebase use. A prescaler divides the clock, and the main counter advances once per prescaler wrap. When the counter reaches the auto-reload limit, the next count tick wraps it to zero and signals an overflow. Overflows, and updates forced by software, become update events. An update event reloads the working copies of the prescaler and reload values. It also pulses a trigger output and may latch a sticky request flag.

Software reaches the block through a flat register port with one write strobe and a combinational read. The port is a register file, not a bus protocol. Three gates act separately:
- update disable stops update events altogether, but a forced update still restarts the counter;
- the request-source select limits the request flag to genuine overflows;
- one-pulse mode makes the hardware drop the run bit at the first update event.

Register addresses on `regAddr`:
- 0: control;
- 1: request enable;
- 2: status flag;
- 3: force-update;
- 4: counter;
- 5: prescaler preload;
- 6: reload preload.

Top module: `tmr_basic`

## Requirements
- R1: After reset the control register reads 0x0000, the counter reads 0, the prescaler preload reads 0, the reload preload reads 0xFFFF, the status flag and `updReq` are 0, and `trgOut` is 0.
- R2: With run bit (control bit 0) set, prescaler value P and reload value A, N clock edges after the run bit is written the counter reads floor(N/(P+1)) mod (A+1), starting from a restarted counter.
- R3: While control bit 0 is 0, the counter value holds.
- R4: With one-pulse mode (control bit 3) set, the first update event clears control bit 0 in hardware and the counter stays at 0 afterwards.
- R5: With update disable (control bit 1) at 0, writing 1 to bit 0 of address 3 produces, one cycle after the write edge, an update event: counter and prescaler restart at 0, the working prescaler and reload values load their preloads, and `trgOut` pulses.
- R6: With control bit 1 at 1, neither overflow nor a forced update produces an update event (`trgOut` stays 0, flag not set, working prescaler unchanged), yet a forced update still restarts counter and prescaler.
- R7: With request source (control bit 2) at 0, both overflow and forced updates set the status flag (address 2 bit 0); with bit 2 at 1, only overflow sets it.
- R8: With reload shadowing (control bit 7) at 0, a write to address 6 takes effect at once; with bit 7 at 1 the new reload value is used only after the next update event.
- R9: Control register bits other than 0, 1, 2, 3 and 7 always read 0.
- R10: Address 3 bit 0 reads 1 in the cycle after it is written with 1 and reads 0 one cycle later.
- R11: The status flag stays set until software writes 0 to address 2 bit 0 (writing 1 leaves it set); `updReq` equals the flag ANDed with address 1 bit 0.
- R12: `trgOut` is high for exactly the one cycle following each update event, including each overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address for read and write |
| regWdata | input | 16 | Write data |
| regRdata | output | 16 | Read data for `regAddr` (combinational) |
| updReq | output | 1 | Update interrupt/DMA request (flag AND enable) |
| trgOut | output | 1 | One-cycle trigger pulse per update event |

## Verification
The assertions watch the following on every cycle:
- the counter holds while stopped;
- a forced update restarts the counter;
- a wrap lands at zero;
- one-pulse mode drops the run bit;
- a disabled update path never pulses the trigger;
- the request source leaves the flag alone on a forced update;
- the force bit clears itself;
- reserved control bits stay zero.

Only the bench scenarios can show the arithmetic of the divider and counter across a sweep of prescaler and reload values. The same holds for the timing of deferred versus immediate reload, for the working prescaler keeping its old value under update disable, and for the sticky flag's interplay with the enable.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_IEN  = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_STS  = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_EVG  = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_CNT  = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_PSC  = 3'd5;
  localparam logic [ADDR_W-1:0] ADDR_ARR  = 3'd6;

  localparam int BIT_RUN = 0;
  localparam int BIT_DIS = 1;
  localparam int BIT_SRC = 2;
  localparam int BIT_OPM = 3;
  localparam int BIT_SHD = 7;

  typedef struct packed {
    logic countEn;
    logic reinit;
    logic loadShadow;
    logic cntWrite;
    logic arrDirect;
  } tmrStrobe_t;

endpackage

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       st,
  input  logic [PSC_W-1:0] pscPre,
  input  logic [CNT_W-1:0] arrPre,
  input  logic [CNT_W-1:0] cntWdata,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [PSC_W-1:0] PSC_ONE = PSC_W'(1);

  logic [PSC_W-1:0] pscCnt;
  logic [PSC_W-1:0] pscShadow;
  logic [CNT_W-1:0] arrShadow;
  logic [CNT_W-1:0] arrEff;
  logic             tick;

  always_comb begin
    arrEff = st.arrDirect ? arrPre : arrShadow;
    tick   = st.countEn && (pscCnt == pscShadow);
    ovf    = tick && (cnt == arrEff);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pscShadow <= '0;
      arrShadow <= '1;
    end else if (st.loadShadow) begin
      pscShadow <= pscPre;
      arrShadow <= arrPre;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pscCnt <= '0;
    end else if (st.reinit) begin
      pscCnt <= '0;
    end else if (st.countEn) begin
      pscCnt <= tick ? '0 : pscCnt + PSC_ONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (st.reinit) begin
      cnt <= '0;
    end else if (st.cntWrite) begin
      cnt <= cntWdata;
    end else if (tick) begin
      cnt <= ovf ? '0 : cnt + CNT_ONE;
    end
  end

  assert_count_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!st.countEn && !st.reinit && !st.cntWrite) |=> $stable(cnt));

  assert_reinit_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    st.reinit |=> (cnt == '0 && pscCnt == '0));

  assert_wrap_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ovf && !st.reinit && !st.cntWrite) |=> (cnt == '0));

endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CNT_W-1:0]  regWdata,
  output logic [CNT_W-1:0]  regRdata,
  input  logic              ovf,
  input  logic [CNT_W-1:0]  cnt,
  output tmrStrobe_t        st,
  output logic [PSC_W-1:0]  pscPre,
  output logic [CNT_W-1:0]  arrPre,
  output logic [CNT_W-1:0]  cntWdata,
  output logic              updReq,
  output logic              trgOut
);

  localparam logic [CNT_W-1:0] CTRL_MASK =
    CNT_W'((1 << BIT_RUN) | (1 << BIT_DIS) | (1 << BIT_SRC) | (1 << BIT_OPM) | (1 << BIT_SHD));

  logic runEn, updDis, updSrc, onePulse, shdEn;
  logic reqEn, flag, ugBit;
  logic wrCtrl, wrIen, wrSts, wrEvg, wrCnt, wrPsc, wrArr;
  logic uev, reqEv;
  logic [CNT_W-1:0] ctrlView;

  always_comb begin
    wrCtrl = regWe && (regAddr == ADDR_CTRL);
    wrIen  = regWe && (regAddr == ADDR_IEN);
    wrSts  = regWe && (regAddr == ADDR_STS);
    wrEvg  = regWe && (regAddr == ADDR_EVG);
    wrCnt  = regWe && (regAddr == ADDR_CNT);
    wrPsc  = regWe && (regAddr == ADDR_PSC);
    wrArr  = regWe && (regAddr == ADDR_ARR);
    uev    = !updDis && (ovf || ugBit);
    reqEv  = uev && (ovf || !updSrc);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runEn    <= 1'b0;
      updDis   <= 1'b0;
      updSrc   <= 1'b0;
      onePulse <= 1'b0;
      shdEn    <= 1'b0;
    end else if (wrCtrl) begin
      runEn    <= regWdata[BIT_RUN];
      updDis   <= regWdata[BIT_DIS];
      updSrc   <= regWdata[BIT_SRC];
      onePulse <= regWdata[BIT_OPM];
      shdEn    <= regWdata[BIT_SHD];
    end else if (uev && onePulse) begin
      runEn    <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqEn  <= 1'b0;
      flag   <= 1'b0;
      ugBit  <= 1'b0;
      trgOut <= 1'b0;
      pscPre <= '0;
      arrPre <= '1;
    end else begin
      ugBit  <= wrEvg && regWdata[0];
      trgOut <= uev;
      if (wrIen) reqEn <= regWdata[0];
      if (reqEv) flag <= 1'b1;
      else if (wrSts && !regWdata[0]) flag <= 1'b0;
      if (wrPsc) pscPre <= PSC_W'(regWdata);
      if (wrArr) arrPre <= regWdata;
    end
  end

  always_comb begin
    st.countEn    = runEn;
    st.reinit     = ugBit;
    st.loadShadow = uev;
    st.cntWrite   = wrCnt;
    st.arrDirect  = !shdEn;
    cntWdata      = regWdata;
    updReq        = flag && reqEn;
  end

  always_comb begin
    ctrlView          = '0;
    ctrlView[BIT_RUN] = runEn;
    ctrlView[BIT_DIS] = updDis;
    ctrlView[BIT_SRC] = updSrc;
    ctrlView[BIT_OPM] = onePulse;
    ctrlView[BIT_SHD] = shdEn;
    case (regAddr)
      ADDR_CTRL: regRdata = ctrlView;
      ADDR_IEN:  regRdata = CNT_W'(reqEn);
      ADDR_STS:  regRdata = CNT_W'(flag);
      ADDR_EVG:  regRdata = CNT_W'(ugBit);
      ADDR_CNT:  regRdata = cnt;
      ADDR_PSC:  regRdata = CNT_W'(pscPre);
      ADDR_ARR:  regRdata = arrPre;
      default:   regRdata = '0;
    endcase
  end

  assert_opm_stop_R4: assert property (@(posedge clk) disable iff (!rstN)
    (uev && onePulse && !wrCtrl) |=> !runEn);

  assert_dis_no_trig_R6: assert property (@(posedge clk) disable iff (!rstN)
    updDis |=> !trgOut);

  assert_src_keep_flag_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ugBit && !ovf && updSrc && !wrSts) |=> $stable(flag));

  assert_ug_selfclear_R10: assert property (@(posedge clk) disable iff (!rstN)
    (ugBit && !(wrEvg && regWdata[0])) |=> !ugBit);

  assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_CTRL) |-> ((regRdata & ~CTRL_MASK) == '0));

endmodule

// File: rtl/tmr_basic.sv
module tmr_basic
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CNT_W-1:0]  regWdata,
  output logic [CNT_W-1:0]  regRdata,
  output logic              updReq,
  output logic              trgOut
);

  tmrStrobe_t       st;
  logic [PSC_W-1:0] pscPre;
  logic [CNT_W-1:0] arrPre;
  logic [CNT_W-1:0] cntWdata;
  logic [CNT_W-1:0] cnt;
  logic             ovf;

  tmr_ctrl #(.CNT_W(CNT_W), .PSC_W(PSC_W)) uCtrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .ovf(ovf), .cnt(cnt),
    .st(st), .pscPre(pscPre), .arrPre(arrPre), .cntWdata(cntWdata),
    .updReq(updReq), .trgOut(trgOut)
  );

  tmr_datapath #(.CNT_W(CNT_W), .PSC_W(PSC_W)) uDp (
    .clk(clk), .rstN(rstN), .st(st), .pscPre(pscPre), .arrPre(arrPre),
    .cntWdata(cntWdata), .cnt(cnt), .ovf(ovf)
  );

endmodule

// File: tb/tmr_basic_test.sv
module tmr_basic_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] RUN = 16'h0001, DIS = 16'h0002, SRC = 16'h0004,
                          OPM = 16'h0008, SHD = 16'h0080;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0;
  logic [2:0] regAddr = 3'd0;
  logic [15:0] regWdata = 16'd0;
  logic [15:0] regRdata;
  logic updReq, trgOut;
  int total = 0;
  int bad = 0;
  logic [15:0] rv;

  tmr_basic uut (.clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
                 .regWdata(regWdata), .regRdata(regRdata), .updReq(updReq), .trgOut(trgOut));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(posedge clk); #1;
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    regAddr = a; #1; d = regRdata;
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1; #1;
    // R1 reset state
    rd(0, rv); chk("R1 ctrl", rv, 0);
    rd(4, rv); chk("R1 cnt", rv, 0);
    rd(5, rv); chk("R1 psc", rv, 0);
    rd(6, rv); chk("R1 arr", rv, 16'hFFFF);
    rd(2, rv); chk("R1 flag", rv, 0);
    chk("R1 updReq", updReq, 0);
    chk("R1 trg", trgOut, 0);

    // R2 R8 R12 sweep of prescaler and reload
    for (int p = 0; p < 3; p++) begin
      for (int a = 1; a < 4; a++) begin
        int per, nmax;
        per = (p + 1) * (a + 1);
        nmax = 2 * per + 1;
        wr(0, SRC);
        wr(5, 16'(p));
        wr(3, 16'd1); step(1);
        wr(6, 16'(a));   // immediate reload (R8)
        wr(2, 16'd0);
        wr(0, SRC | RUN);
        for (int n = 1; n <= nmax; n++) begin
          step(1);
          rd(4, rv);
          chk("R2 count", rv, (n / (p + 1)) % (a + 1));
          chk("R12 trigger", trgOut, (n % per == 0) ? 1 : 0);
        end
        rd(2, rv); chk("R7 overflow sets flag", rv, 1);
      end
    end

    // R3 hold while stopped
    wr(0, SRC);
    rd(4, rv);
    begin
      logic [15:0] c0;
      c0 = rv;
      step(6);
      rd(4, rv); chk("R3 hold", rv, c0);
    end

    // R4 one-pulse
    wr(5, 16'd0); wr(3, 16'd1); step(1);
    wr(6, 16'd2); wr(2, 16'd0);
    wr(0, SRC | RUN | OPM);
    step(3);
    chk("R4 trg at stop", trgOut, 1);
    rd(0, rv); chk("R4 run cleared", rv & 16'h1, 0);
    step(4);
    rd(4, rv); chk("R4 counter parked", rv, 0);

    // R6 update disable
    wr(2, 16'd0);
    wr(0, RUN | DIS);
    for (int i = 0; i < 8; i++) begin
      step(1);
      chk("R6 no trigger", trgOut, 0);
    end
    rd(2, rv); chk("R6 no flag", rv, 0);
    wr(5, 16'd2);
    wr(3, 16'd1);
    rd(3, rv); chk("R10 ug reads 1", rv, 1);
    step(1);
    rd(3, rv); chk("R10 ug cleared", rv, 0);
    rd(4, rv); chk("R6 restart", rv, 0);
    chk("R6 trg", trgOut, 0);
    step(1);
    rd(4, rv); chk("R6 old prescaler kept", rv, 1);

    // R5 forced update with updates enabled, source 0
    wr(0, RUN);
    wr(2, 16'd0);
    wr(3, 16'd1); step(1);
    rd(4, rv); chk("R5 restart", rv, 0);
    chk("R5 trg", trgOut, 1);
    rd(2, rv); chk("R7 src0 ug sets flag", rv, 1);
    step(2);
    rd(4, rv); chk("R5 new prescaler", rv, 0);
    step(1);
    rd(4, rv); chk("R5 new prescaler tick", rv, 1);

    // R7 source 1: forced update leaves flag
    wr(2, 16'd0);
    wr(0, RUN | SRC);
    wr(3, 16'd1); step(1);
    chk("R7 trg", trgOut, 1);
    rd(2, rv); chk("R7 src1 ug no flag", rv, 0);
    step(9);
    chk("R7 overflow trg", trgOut, 1);
    rd(2, rv); chk("R7 src1 overflow flag", rv, 1);

    // R11 sticky flag and request gating
    wr(0, SRC);
    wr(2, 16'd1);
    rd(2, rv); chk("R11 write1 keeps", rv, 1);
    chk("R11 req gated", updReq, 0);
    wr(1, 16'd1);
    chk("R11 req on", updReq, 1);
    wr(2, 16'd0);
    rd(2, rv); chk("R11 cleared", rv, 0);
    chk("R11 req off", updReq, 0);

    // R8 deferred reload
    wr(0, SHD | SRC);
    wr(5, 16'd0); wr(6, 16'd1);
    wr(3, 16'd1); step(1);
    wr(6, 16'd5);
    wr(0, SHD | SRC | RUN);
    step(2);
    rd(4, rv); chk("R8 old reload wrap", rv, 0);
    chk("R8 trg", trgOut, 1);
    step(2);
    rd(4, rv); chk("R8 new reload used", rv, 2);

    // R9 reserved bits
    wr(0, 16'hFFFF);
    rd(0, rv); chk("R9 reserved", rv, 16'h008F);
    wr(0, 16'h0000);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule